// File: doc/BRIEF.md
# Four-Channel Power-Good Sequencer

A synchronous controller that brings up four downstream power domains in a fixed order. It waits until the internal lockout/power-on-reset flag is ready and both supply-window flags report the input voltage in range. It then runs an initial ramp interval and activates enable A. B, C and D follow in turn, each after its own programmed delay counted from the previous enable's activation. The ramp is modelled as a digital counter.

All delays count ticks of a slow timebase that a prescaler derives from the system clock. With the default divider a tick is 1 ms at 200 MHz, and 8-bit delay values reach beyond 200 ms. If the window closes at any time, during start-up or afterwards, all enables drop at once and the ramp count is cleared. A complete new sequence starts as soon as the window reopens. One parameter selects whether an active enable is high or low.

Top module: `pgood_sequencer`

## Requirements
- R1: While `rst_n` is low, every enable sits at its inactive level and `stage` reads 0.
- R2: The enables become active strictly in the order A (bit 0), B (bit 1), C (bit 2), D (bit 3). The active set is always one of {}, {A}, {A,B}, {A,B,C}, {A,B,C,D}.
- R3: Let both window flags go high ahead of a rising edge while `porReady` is high. Enable A becomes active right after the (4 + rampDly*TICK_DIV)-th rising edge, counting that edge as the first. This includes two synchronizer stages and one edge to start the ramp.
- R4: B, C and D each become active exactly dly*TICK_DIV + 1 cycles after the previous enable, where dly is `dlyB`, `dlyC` or `dlyD`. A delay of 0 gives one cycle.
- R5: Each delay value is sampled when its stage begins. A change to that input while the stage is running has no effect on the current stage.
- R6: A low `uvOk` or `ovOk` reaches the enables after two rising edges, through the synchronizer. In that cycle every enable goes inactive, combinationally. A window that closes in the cycle where the ramp would start or a stage would advance wins, and no enable becomes active.
- R7: After a fault the ramp count is discarded. When the window reopens, A follows the full ramp interval of R3, even if the fault cut a ramp short.
- R8: `porReady` is not synchronized. When it is low, the enables are inactive in the same cycle and `stage` is 0 after the next edge. No sequence runs while it stays low. Once it rises with the flags already valid, A is active after 2 + rampDly*TICK_DIV edges.
- R9: With `PG_ACTIVE_HIGH`=1 an active enable is 1. With 0 an active enable is 0 and an inactive enable is 1.
- R10: `stage` encodes 0 idle, 1 ramp, 2 A active waiting for B, 3 waiting for C, 4 waiting for D, 5 all four active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porReady | input | 1 | Internal lockout/power-on-reset satisfied |
| uvOk | input | 1 | Input above undervoltage limit (hysteresis already applied) |
| ovOk | input | 1 | Input below overvoltage limit (hysteresis already applied) |
| rampDly | input | DLY_W | Initial ramp interval in ticks |
| dlyB | input | DLY_W | Delay from A to B in ticks |
| dlyC | input | DLY_W | Delay from B to C in ticks |
| dlyD | input | DLY_W | Delay from C to D in ticks |
| pgood | output | 4 | Enables A..D in bits 0..3, polarity per PG_ACTIVE_HIGH |
| stage | output | 3 | Current sequence stage, encoded per R10 |

## Verification
The delicate overlap is a synchronized window fault that arrives in the same cycle in which the controller would start the ramp or advance a stage and load the next delay. The clear must win over the load. The bench provokes this with a one-cycle pulse on `uvOk`, so that the window is valid for exactly one synchronized cycle. It then checks that no enable ever activates and that `stage` returns to 0. Near-exhaustive sweeps of ramp and inter-stage delays are compared against activation times computed arithmetically from the tick divider.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  localparam int NUM_OUT = 4;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RAMP   = 3'd1,
    ST_WAIT_B = 3'd2,
    ST_WAIT_C = 3'd3,
    ST_WAIT_D = 3'd4,
    ST_DONE   = 3'd5
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_RAMP = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_D    = 2'd3
  } dlySel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;   // load selected delay, restart prescaler
    dlySel_t sel;    // which delay to load
    logic    clear;  // discharge: zero counter and prescaler
  } dpStrobe_t;

endpackage

// File: rtl/pgseq_sync.sv
module pgseq_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pgseq_datapath.sv
module pgseq_datapath
  import pgseq_pkg::*;
#(
  parameter int TICK_DIV = 200000,
  parameter int DLY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strb,
  input  logic [DLY_W-1:0] rampDly,
  input  logic [DLY_W-1:0] dlyB,
  input  logic [DLY_W-1:0] dlyC,
  input  logic [DLY_W-1:0] dlyD,
  output logic             dlyDone
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic             tick;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] dlyTab [NUM_OUT];
  logic [DLY_W-1:0] dlySelVal;

  // Timebase prescaler; restarts with every stage so delays are phase-exact
  generate
    if (TICK_DIV > 1) begin : g_presc
      logic [PRE_W-1:0] presc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       presc <= '0;
        else if (strb.load || strb.clear) presc <= '0;
        else if (presc == PRE_MAX)        presc <= '0;
        else                              presc <= presc + PRE_W'(1);
      end
      assign tick = (presc == PRE_MAX);

      a_r4_presc_range: assert property (@(posedge clk) disable iff (!rst_n)
        presc <= PRE_MAX);
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  assign dlyTab[SEL_RAMP] = rampDly;
  assign dlyTab[SEL_B]    = dlyB;
  assign dlyTab[SEL_C]    = dlyC;
  assign dlyTab[SEL_D]    = dlyD;
  assign dlySelVal        = dlyTab[strb.sel];

  // Stage delay counter, also the modelled ramp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (strb.clear)              cnt <= '0;
    else if (strb.load)               cnt <= dlySelVal;
    else if (tick && cnt != '0)       cnt <= cnt - DLY_W'(1);
  end

  assign dlyDone = (cnt == '0);

  // R5: between loads the counter only holds or steps down by one
  a_r5_no_reload_midstage: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.load && !strb.clear) |=> (cnt == $past(cnt) || cnt == $past(cnt) - DLY_W'(1)));

  // R7: a clear always empties the ramp count
  a_r7_clear_discharges: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> cnt == '0);

endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
  import pgseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               winOk,
  input  logic               dlyDone,
  output dpStrobe_t          strb,
  output seqState_t          state,
  output logic [NUM_OUT-1:0] actVec
);

  seqState_t  nextState;
  logic [2:0] stateBits;

  always_comb begin
    nextState  = state;
    strb.load  = 1'b0;
    strb.sel   = SEL_RAMP;
    strb.clear = 1'b0;
    if (!winOk) begin
      // fault wins over any advance in the same cycle
      nextState  = ST_IDLE;
      strb.clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nextState = ST_RAMP;
          strb.load = 1'b1;
          strb.sel  = SEL_RAMP;
        end
        ST_RAMP: if (dlyDone) begin
          nextState = ST_WAIT_B;
          strb.load = 1'b1;
          strb.sel  = SEL_B;
        end
        ST_WAIT_B: if (dlyDone) begin
          nextState = ST_WAIT_C;
          strb.load = 1'b1;
          strb.sel  = SEL_C;
        end
        ST_WAIT_C: if (dlyDone) begin
          nextState = ST_WAIT_D;
          strb.load = 1'b1;
          strb.sel  = SEL_D;
        end
        ST_WAIT_D: if (dlyDone) nextState = ST_DONE;
        ST_DONE:   nextState = ST_DONE;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign stateBits = state;

  // Enable i is active from stage WAIT_B+i onward
  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_act
      assign actVec[i] = (stateBits >= 3'(int'(ST_WAIT_B) + i));
    end
  endgenerate

  // R2: stages step forward one at a time or fall back to idle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stateBits == $past(stateBits) || stateBits == 3'd0 ||
               stateBits == $past(stateBits) + 3'd1));

  // R4: a timed stage cannot advance before the datapath reports expiry
  a_r4_wait_for_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (stateBits >= 3'd1 && stateBits <= 3'd4 && !dlyDone) |=>
      (stateBits == $past(stateBits) || stateBits == 3'd0));

  // R6: a closed window always returns to idle on the next edge
  a_r6_fault_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !winOk |=> stateBits == 3'd0);

endmodule

// File: rtl/pgood_sequencer.sv
module pgood_sequencer
  import pgseq_pkg::*;
#(
  parameter int TICK_DIV       = 200000,
  parameter int DLY_W          = 8,
  parameter bit PG_ACTIVE_HIGH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               porReady,
  input  logic               uvOk,
  input  logic               ovOk,
  input  logic [DLY_W-1:0]   rampDly,
  input  logic [DLY_W-1:0]   dlyB,
  input  logic [DLY_W-1:0]   dlyC,
  input  logic [DLY_W-1:0]   dlyD,
  output logic [NUM_OUT-1:0] pgood,
  output logic [2:0]         stage
);

  logic [1:0]         okSync;
  logic               winOk;
  logic               dlyDone;
  dpStrobe_t          strb;
  seqState_t          state;
  logic [NUM_OUT-1:0] actVec;
  logic [NUM_OUT-1:0] actGated;

  pgseq_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({uvOk, ovOk}),
    .dout (okSync)
  );

  assign winOk = porReady & okSync[1] & okSync[0];

  pgseq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .winOk  (winOk),
    .dlyDone(dlyDone),
    .strb   (strb),
    .state  (state),
    .actVec (actVec)
  );

  pgseq_datapath #(.TICK_DIV(TICK_DIV), .DLY_W(DLY_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .rampDly(rampDly),
    .dlyB   (dlyB),
    .dlyC   (dlyC),
    .dlyD   (dlyD),
    .dlyDone(dlyDone)
  );

  // Fault gating acts in the same cycle the synchronized fault appears
  assign actGated = actVec & {NUM_OUT{winOk}};

  generate
    if (PG_ACTIVE_HIGH) begin : g_pol_hi
      assign pgood = actGated;
    end else begin : g_pol_lo
      assign pgood = ~actGated;
    end
  endgenerate

  assign stage = state;

  // R8: lockout forces the idle stage on the following edge
  a_r8_lockout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !porReady |=> stage == 3'd0);

  // R2: D is never active without A
  a_r2_d_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
    actGated[3] |-> actGated[0]);

endmodule

// File: tb/sim_pgood_sequencer.sv
`timescale 1ns/1ps
module sim_pgood_sequencer;

  localparam int DIV = 3;
  localparam int DW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          porReady = 1'b1;
  logic          uvOk = 1'b1;
  logic          ovOk = 1'b1;
  logic [DW-1:0] rampDly = '0, dlyB = '0, dlyC = '0, dlyD = '0;
  logic [3:0]    pg0, pg1;
  logic [2:0]    st0, st1;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pgood_sequencer #(.TICK_DIV(DIV), .DLY_W(DW), .PG_ACTIVE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .porReady(porReady), .uvOk(uvOk), .ovOk(ovOk),
    .rampDly(rampDly), .dlyB(dlyB), .dlyC(dlyC), .dlyD(dlyD),
    .pgood(pg0), .stage(st0));

  pgood_sequencer #(.TICK_DIV(DIV), .DLY_W(DW), .PG_ACTIVE_HIGH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .porReady(porReady), .uvOk(uvOk), .ovOk(ovOk),
    .rampDly(rampDly), .dlyB(dlyB), .dlyC(dlyC), .dlyD(dlyD),
    .pgood(pg1), .stage(st1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bring the window down long enough to reach idle
  task automatic goIdle();
    @(negedge clk);
    uvOk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Count edges until enable bit idx is active (returns -1 on timeout)
  task automatic edgesUntil(input int idx, input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); @(negedge clk);
      if (pg0[idx]) begin n = k; break; end
    end
  endtask

  task automatic runSeq(input int r, input int b, input int c, input int d);
    int  tFirst[4];
    int  expT[4];
    bit  thermoOk = 1'b1;
    bit  polOk = 1'b1;
    goIdle();
    rampDly = DW'(r); dlyB = DW'(b); dlyC = DW'(c); dlyD = DW'(d);
    uvOk = 1'b1;
    expT[0] = 4 + r * DIV;
    expT[1] = expT[0] + b * DIV + 1;
    expT[2] = expT[1] + c * DIV + 1;
    expT[3] = expT[2] + d * DIV + 1;
    for (int i = 0; i < 4; i++) tFirst[i] = -1;
    for (int k = 1; k <= expT[3] + 3; k++) begin
      @(posedge clk); @(negedge clk);
      for (int i = 0; i < 4; i++) if (pg0[i] && tFirst[i] < 0) tFirst[i] = k;
      if (!(pg0 inside {4'h0, 4'h1, 4'h3, 4'h7, 4'hF})) thermoOk = 1'b0;
      if (pg1 !== ~pg0) polOk = 1'b0;
    end
    chk(tFirst[0] == expT[0], "R3 ramp to A", tFirst[0], expT[0]);
    for (int i = 1; i < 4; i++)
      chk(tFirst[i] == expT[i], "R4 stage delay", tFirst[i], expT[i]);
    chk(thermoOk, "R2 order", int'(pg0), 15);
    chk(polOk, "R9 polarity", int'(pg1), int'(~pg0 & 4'hF));
    chk(st0 == 3'd5, "R10 stage done", int'(st0), 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pg0 == 4'h0, "R1 reset outputs", int'(pg0), 0);
    chk(pg1 == 4'hF, "R1 R9 reset low-polarity outputs", int'(pg1), 15);
    chk(st0 == 3'd0, "R1 reset stage", int'(st0), 0);
    rst_n = 1'b1;

    // Sweep ramp and inter-stage delays: R2 R3 R4 R9 R10
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 8; b++)
        runSeq(r, b, (r + b) % 8, 7 - r);

    // R10: intermediate stage encodings
    goIdle();
    rampDly = 3'd2; dlyB = 3'd3; dlyC = 3'd3; dlyD = 3'd3;
    uvOk = 1'b1;
    repeat (3) @(negedge clk);
    chk(st0 == 3'd1, "R10 stage ramp", int'(st0), 1);
    edgesUntil(0, 100, n);
    chk(st0 == 3'd2, "R10 stage wait B", int'(st0), 2);

    // R5: change dlyB mid-stage, B must keep original 5-tick delay
    goIdle();
    rampDly = 3'd0; dlyB = 3'd5; dlyC = 3'd0; dlyD = 3'd0;
    uvOk = 1'b1;
    edgesUntil(0, 20, n);
    chk(n == 4, "R5 A activation", n, 4);
    dlyB = 3'd0;
    edgesUntil(1, 100, n);
    chk(n == 5 * DIV + 1, "R5 delay sampled at stage entry", n, 5 * DIV + 1);

    // R6 then R7: fault after completion, then recovery with full ramp
    runSeq(2, 1, 1, 1);
    ovOk = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pg0 == 4'hF, "R6 sync latency first edge", int'(pg0), 15);
    @(posedge clk); @(negedge clk);
    chk(pg0 == 4'h0, "R6 fault clears outputs", int'(pg0), 0);
    chk(pg1 == 4'hF, "R6 R9 fault low-polarity", int'(pg1), 15);
    @(posedge clk); @(negedge clk);
    chk(st0 == 3'd0, "R6 stage idle after fault", int'(st0), 0);
    ovOk = 1'b1;
    edgesUntil(0, 100, n);
    chk(n == 4 + 2 * DIV, "R7 restart after fault", n, 4 + 2 * DIV);

    // R7: fault cuts ramp short; recovery runs full ramp
    goIdle();
    rampDly = 3'd5;
    uvOk = 1'b1;
    repeat (4 + 2 * DIV) @(negedge clk);
    chk(pg0 == 4'h0, "R7 mid-ramp no output", int'(pg0), 0);
    uvOk = 1'b0;
    repeat (3) @(negedge clk);
    uvOk = 1'b1;
    edgesUntil(0, 100, n);
    chk(n == 4 + 5 * DIV, "R7 ramp discharged", n, 4 + 5 * DIV);

    // R6: one-cycle window collides with ramp start; nothing activates
    goIdle();
    rampDly = 3'd0; dlyB = 3'd0; dlyC = 3'd0; dlyD = 3'd0;
    uvOk = 1'b1;
    @(negedge clk);
    uvOk = 1'b0;
    begin
      bit anyAct = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (pg0 != 4'h0) anyAct = 1'b1;
      end
      chk(!anyAct, "R6 fault beats advance", int'(anyAct), 0);
    end
    chk(st0 == 3'd0, "R6 collision stage idle", int'(st0), 0);

    // R8: lockout drop is immediate and blocks the sequence
    runSeq(1, 0, 0, 0);
    porReady = 1'b0;
    #1;
    chk(pg0 == 4'h0, "R8 lockout immediate", int'(pg0), 0);
    @(posedge clk); @(negedge clk);
    chk(st0 == 3'd0, "R8 lockout stage", int'(st0), 0);
    repeat (8) @(negedge clk);
    chk(pg0 == 4'h0, "R8 no sequence under lockout", int'(pg0), 0);
    rampDly = 3'd1;
    porReady = 1'b1;
    edgesUntil(0, 100, n);
    chk(n == 2 + 1 * DIV, "R8 start after lockout release", n, 2 + DIV);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule